// File: doc/BRIEF.md
# Serial-Clock Driven Power-State Sequencer

This block tracks the power condition of a sensor that streams samples over an I2S-style bit clock. It watches two things: the enable pin, and whether the serial bit clock is toggling. From these it keeps a state: boot warm-up, run, clock-idle sleep, or shut-off. Each wake-up path has its own settling interval before the data path is unmuted.

Every interval is measured in serial clock rising edges. An interval waits while the serial clock is quiet. A free-running local clock samples the serial clock through a two-stage synchronizer. It also measures how long the serial clock has been quiet, and declares the clock stopped after a programmable number of local cycles.

While not in the run state, the sample bus is forced to zero. When enable drops during clock-idle sleep, the block goes through shut-off and raises a sticky protocol-violation flag. The rest of the chip uses the state code, the unmute flag and the two low-power flags to gate the serializer and the analog supplies.

Top module: `sck_power_sequencer`

## Requirements
- R1: While reset is asserted, and right after it is released, the state code is 0 (boot warm-up). The unmute flag, both low-power flags, the violation flag and the sample output are all zero.
- R2: With enable high, boot warm-up stays in state code 0 until exactly LEN_BOOT serial-clock rising edges have been seen. After the edge numbered LEN_BOOT the state code becomes 1 (run) and the unmute flag rises. When no serial clock is present, boot warm-up does not advance.
- R3: The sample output equals the sample input while the unmute flag is high, and is all zeros otherwise.
- R4: In run with enable high, when no serial-clock edge arrives for `stop_limit` local cycles, the state code becomes 2 (clock-idle sleep) and the standby flag rises. A gap shorter than `stop_limit` leaves the block in run.
- R5: The first rising edge in clock-idle sleep moves the block to state code 3 (sleep wake-up). That edge is not counted. Run resumes after LEN_IDLE further rising edges.
- R6: A low enable moves the block to state code 4 (shut-off) from any state, whether or not the serial clock runs. The power-down flag is high in state 4.
- R7: When enable returns high in shut-off, the block moves to state code 5 (shut-off wake-up). Run resumes after LEN_OFF rising edges. A quiet serial clock during this wake-up pauses the count and does not lead to clock-idle sleep.
- R8: A wake-up that is cut short by a low enable restarts its count from zero on the next wake-up.
- R9: A low enable in clock-idle sleep leads to state code 4 and sets the violation flag. The flag stays set until reset. Clock-idle sleep is never left directly for state code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_in | input | 1 | Serial bit clock, sampled by clk |
| chip_en | input | 1 | Enable pin, synchronous to clk |
| stop_limit | input | IDLE_W | Quiet local cycles before the serial clock counts as stopped |
| data_in | input | DATA_W | Sample word from the converter path |
| data_out | output | DATA_W | Sample word, zero while muted |
| state_code | output | 3 | Current state (0 boot warm-up, 1 run, 2 sleep, 3 sleep wake-up, 4 shut-off, 5 shut-off wake-up) |
| out_valid | output | 1 | Unmute flag, high only in run |
| in_standby | output | 1 | High in clock-idle sleep |
| in_powerdown | output | 1 | High in shut-off |
| proto_err | output | 1 | Sticky flag: enable dropped during sleep |

## Verification
The bench drives each warm-up to one edge short of its length and then to the full length. An off-by-one counter would unmute one edge early or one edge late. A short gap in the serial clock must not cause sleep; a timeout compared against the wrong bound would drop into sleep on every slow clock. The bench also stops the serial clock in the middle of the shut-off wake-up, cuts a wake-up short and starts it again, and drops enable during sleep. A counter that is not cleared would unmute too early, and a missing violation path would leave the flag low or jump straight into a wake-up.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PS_BOOT_WARM = 3'd0,
    PS_RUN       = 3'd1,
    PS_IDLE      = 3'd2,
    PS_IDLE_WARM = 3'd3,
    PS_OFF       = 3'd4,
    PS_OFF_WARM  = 3'd5
  } pstate_e;

  function automatic int unsigned max_of3(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sck_activity_mon.sv
module sck_activity_mon #(
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_in,
  input  logic [IDLE_W-1:0] stop_limit,
  output logic              sck_rise,
  output logic              sck_stopped
);

  localparam logic [IDLE_W-1:0] IDLE_SAT = {IDLE_W{1'b1}};

  logic              sync1_q, sync2_q, hist_q;
  logic              any_edge;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              stop_q, stop_d;
  logic              idle_en;

  // two-stage synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hist_q  <= 1'b0;
    end else begin
      sync1_q <= sck_in;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
    end
  end

  assign any_edge = sync2_q ^ hist_q;
  assign sck_rise = sync2_q & ~hist_q;

  // quiet-time measurement
  always_comb begin
    idle_d = idle_q;
    stop_d = stop_q;
    if (any_edge) begin
      idle_d = '0;
      stop_d = 1'b0;
    end else if (!stop_q) begin
      if (idle_q != IDLE_SAT) begin
        idle_d = idle_q + 1'b1;
      end
      if (idle_d >= stop_limit) begin
        stop_d = 1'b1;
      end
    end
  end

  assign idle_en = any_edge | ~stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      stop_q <= 1'b1;
    end else if (idle_en) begin
      idle_q <= idle_d;
      stop_q <= stop_d;
    end
  end

  assign sck_stopped = stop_q;

endmodule

// File: rtl/warm_counter.sv
module warm_counter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] target,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | step;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // asserted on the edge that completes the interval
  assign last = step & (cnt_q == (target - 1'b1));

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwrseq_pkg::*;
#(
  parameter int unsigned LEN_BOOT = 262144,
  parameter int unsigned LEN_IDLE = 16384,
  parameter int unsigned LEN_OFF  = 131072,
  parameter int unsigned CNT_W    = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             sck_rise,
  input  logic             sck_stopped,
  input  logic             warm_last,
  output pstate_e          state,
  output logic             warm_on,
  output logic [CNT_W-1:0] warm_target,
  output logic             proto_err
);

  localparam logic [CNT_W-1:0] TGT_BOOT = CNT_W'(LEN_BOOT);
  localparam logic [CNT_W-1:0] TGT_IDLE = CNT_W'(LEN_IDLE);
  localparam logic [CNT_W-1:0] TGT_OFF  = CNT_W'(LEN_OFF);

  pstate_e state_q, state_d;
  logic    err_q, err_set;

  // next-state logic: a low enable overrides everything else
  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    if (!chip_en) begin
      state_d = PS_OFF;
      err_set = (state_q == PS_IDLE);
    end else begin
      case (state_q)
        PS_BOOT_WARM: if (warm_last)   state_d = PS_RUN;
        PS_RUN:       if (sck_stopped) state_d = PS_IDLE;
        PS_IDLE:      if (sck_rise)    state_d = PS_IDLE_WARM;
        PS_IDLE_WARM: if (warm_last)   state_d = PS_RUN;
        PS_OFF:                        state_d = PS_OFF_WARM;
        PS_OFF_WARM:  if (warm_last)   state_d = PS_RUN;
        default:                       state_d = PS_OFF;
      endcase
    end
  end

  // warm-up selection
  always_comb begin
    warm_on     = 1'b0;
    warm_target = TGT_BOOT;
    case (state_q)
      PS_BOOT_WARM: begin warm_on = 1'b1; warm_target = TGT_BOOT; end
      PS_IDLE_WARM: begin warm_on = 1'b1; warm_target = TGT_IDLE; end
      PS_OFF_WARM:  begin warm_on = 1'b1; warm_target = TGT_OFF;  end
      default:      begin warm_on = 1'b0; warm_target = TGT_BOOT; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_BOOT_WARM;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_set) begin
      err_q <= 1'b1;
    end
  end

  assign state     = state_q;
  assign proto_err = err_q;

endmodule

// File: rtl/sck_power_sequencer.sv
module sck_power_sequencer
  import pwrseq_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned IDLE_W   = 16,
  parameter int unsigned LEN_BOOT = 262144,
  parameter int unsigned LEN_IDLE = 16384,
  parameter int unsigned LEN_OFF  = 131072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_in,
  input  logic              chip_en,
  input  logic [IDLE_W-1:0] stop_limit,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic [2:0]        state_code,
  output logic              out_valid,
  output logic              in_standby,
  output logic              in_powerdown,
  output logic              proto_err
);

  localparam int unsigned LEN_MAX = max_of3(LEN_BOOT, LEN_IDLE, LEN_OFF);
  localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);

  logic             rst_ff1_q, rst_ff2_q;
  logic             rst_n_core;
  logic             sck_rise, sck_stopped;
  logic             warm_on, warm_last;
  logic [CNT_W-1:0] warm_target;
  pstate_e          state;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff1_q <= 1'b0;
      rst_ff2_q <= 1'b0;
    end else begin
      rst_ff1_q <= 1'b1;
      rst_ff2_q <= rst_ff1_q;
    end
  end
  assign rst_n_core = rst_ff2_q;

  sck_activity_mon #(.IDLE_W(IDLE_W)) u_mon (
    .clk         (clk),
    .rst_n       (rst_n_core),
    .sck_in      (sck_in),
    .stop_limit  (stop_limit),
    .sck_rise    (sck_rise),
    .sck_stopped (sck_stopped)
  );

  pwr_state_fsm #(
    .LEN_BOOT (LEN_BOOT),
    .LEN_IDLE (LEN_IDLE),
    .LEN_OFF  (LEN_OFF),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_core),
    .chip_en     (chip_en),
    .sck_rise    (sck_rise),
    .sck_stopped (sck_stopped),
    .warm_last   (warm_last),
    .state       (state),
    .warm_on     (warm_on),
    .warm_target (warm_target),
    .proto_err   (proto_err)
  );

  warm_counter #(.CNT_W(CNT_W)) u_warm (
    .clk    (clk),
    .rst_n  (rst_n_core),
    .clr    (~warm_on),
    .step   (sck_rise & warm_on),
    .target (warm_target),
    .last   (warm_last)
  );

  assign state_code   = state;
  assign out_valid    = (state == PS_RUN);
  assign in_standby   = (state == PS_IDLE);
  assign in_powerdown = (state == PS_OFF);
  assign data_out     = data_in & {DATA_W{out_valid}};

endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
  parameter int unsigned DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic [2:0]        state_code,
  input logic              out_valid,
  input logic              in_standby,
  input logic              in_powerdown,
  input logic              proto_err,
  input logic [DATA_W-1:0] data_out
);

  a_r3_mute_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (data_out == '0));

  a_r6_low_enable_shuts_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (state_code == 3'd4) && in_powerdown);

  a_r9_sleep_violation_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2) && !chip_en |=> (state_code == 3'd4) && proto_err);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  a_r9_no_direct_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2) |=> (state_code == 3'd2) || (state_code == 3'd3) || (state_code == 3'd4));

  a_r4_sleep_only_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 3'd1) && (state_code != 3'd2) |=> (state_code != 3'd2));

  a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 3'd5);

  a_r7_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd4) && chip_en |=> (state_code == 3'd5));

endmodule

bind sck_power_sequencer pwr_seq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_core),
  .chip_en      (chip_en),
  .state_code   (state_code),
  .out_valid    (out_valid),
  .in_standby   (in_standby),
  .in_powerdown (in_powerdown),
  .proto_err    (proto_err),
  .data_out     (data_out)
);

// File: tb/tb_sck_power_sequencer.sv
module tb_sck_power_sequencer;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W     = 24;
  localparam int unsigned IDLE_W     = 16;
  localparam int unsigned LEN_BOOT   = 64;
  localparam int unsigned LEN_IDLE   = 4;
  localparam int unsigned LEN_OFF    = 32;
  localparam int unsigned NSTEP      = 20;

  logic              clk;
  logic              rst_n;
  logic              sck_in;
  logic              chip_en;
  logic [IDLE_W-1:0] stop_limit;
  logic [DATA_W-1:0] data_in;
  logic [DATA_W-1:0] data_out;
  logic [2:0]        state_code;
  logic              out_valid, in_standby, in_powerdown, proto_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sck_power_sequencer #(
    .DATA_W(DATA_W), .IDLE_W(IDLE_W),
    .LEN_BOOT(LEN_BOOT), .LEN_IDLE(LEN_IDLE), .LEN_OFF(LEN_OFF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .chip_en(chip_en),
    .stop_limit(stop_limit), .data_in(data_in), .data_out(data_out),
    .state_code(state_code), .out_valid(out_valid), .in_standby(in_standby),
    .in_powerdown(in_powerdown), .proto_err(proto_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // step: {enable, idle(1)/pulses(0), count[7:0], exp_state[2:0], exp_valid, req[5:0]}
  localparam logic [19:0] STEPS [0:NSTEP-1] = '{
    {1'b1, 1'b1, 8'd40, 3'd0, 1'b0, 6'd2},  // R2 no clock: boot warm-up waits
    {1'b1, 1'b0, 8'd63, 3'd0, 1'b0, 6'd2},  // R2 one edge short
    {1'b1, 1'b0, 8'd1,  3'd1, 1'b1, 6'd2},  // R2 interval complete
    {1'b1, 1'b0, 8'd10, 3'd1, 1'b1, 6'd4},  // R4 running clock keeps run
    {1'b1, 1'b1, 8'd12, 3'd1, 1'b1, 6'd4},  // R4 gap below limit
    {1'b1, 1'b1, 8'd40, 3'd2, 1'b0, 6'd4},  // R4 sleep entered
    {1'b1, 1'b0, 8'd1,  3'd3, 1'b0, 6'd5},  // R5 restart edge, not counted
    {1'b1, 1'b0, 8'd3,  3'd3, 1'b0, 6'd5},  // R5 one short
    {1'b1, 1'b0, 8'd1,  3'd1, 1'b1, 6'd5},  // R5 run again
    {1'b0, 1'b1, 8'd5,  3'd4, 1'b0, 6'd6},  // R6 shut-off, clock quiet
    {1'b0, 1'b0, 8'd5,  3'd4, 1'b0, 6'd6},  // R6 shut-off, clock running
    {1'b1, 1'b0, 8'd20, 3'd5, 1'b0, 6'd7},  // R7 wake-up in progress
    {1'b1, 1'b1, 8'd40, 3'd5, 1'b0, 6'd7},  // R7 quiet clock pauses, no sleep
    {1'b1, 1'b0, 8'd11, 3'd5, 1'b0, 6'd7},  // R7 one short
    {1'b1, 1'b0, 8'd1,  3'd1, 1'b1, 6'd7},  // R7 run
    {1'b0, 1'b1, 8'd3,  3'd4, 1'b0, 6'd8},  // R8 shut-off
    {1'b1, 1'b0, 8'd10, 3'd5, 1'b0, 6'd8},  // R8 partial wake-up
    {1'b0, 1'b1, 8'd3,  3'd4, 1'b0, 6'd8},  // R8 cut short
    {1'b1, 1'b0, 8'd31, 3'd5, 1'b0, 6'd8},  // R8 count restarted from zero
    {1'b1, 1'b0, 8'd1,  3'd1, 1'b1, 6'd8}   // R8 run
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sck_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      sck_in = 1'b1;
      repeat (4) @(negedge clk);
      sck_in = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic idle_for(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_outputs(input string tag, input logic [2:0] st, input logic vld);
    chk({tag, " state"},     32'(state_code),   32'(st));
    chk({tag, " valid"},     32'(out_valid),    32'(vld));
    chk({tag, " standby"},   32'(in_standby),   32'(st == 3'd2));
    chk({tag, " powerdown"}, 32'(in_powerdown), 32'(st == 3'd4));
    chk({tag, " data"},      32'(data_out),     vld ? 32'(data_in) : 32'd0);  // R3
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    sck_in     = 1'b0;
    chip_en    = 1'b1;
    stop_limit = 16'd20;
    data_in    = 24'h5A3C96;
    idle_for(3);
    // R1 reset values
    check_outputs("R1 in reset", 3'd0, 1'b0);
    chk("R1 in reset err", 32'(proto_err), 32'd0);
    rst_n = 1'b1;
    idle_for(4);
    check_outputs("R1 after release", 3'd0, 1'b0);

    for (int i = 0; i < NSTEP; i++) begin
      logic [19:0] s;
      s       = STEPS[i];
      chip_en = s[19];
      data_in = 24'hC0FFEE ^ 24'(i * 24'h010203);
      if (s[18]) idle_for(int'(s[17:10]));
      else       sck_pulses(int'(s[17:10]));
      check_outputs($sformatf("R%0d step %0d", s[5:0], i), s[9:7], s[6]);
      chk($sformatf("R%0d step %0d err", s[5:0], i), 32'(proto_err), 32'd0);
    end

    // R9: enable dropped during sleep
    idle_for(40);
    check_outputs("R9 sleep", 3'd2, 1'b0);
    chip_en = 1'b0;
    idle_for(3);
    check_outputs("R9 forced shut-off", 3'd4, 1'b0);
    chk("R9 flag set", 32'(proto_err), 32'd1);
    chip_en = 1'b1;
    sck_pulses(LEN_OFF - 1);
    check_outputs("R9 via shut-off wake-up", 3'd5, 1'b0);
    sck_pulses(1);
    check_outputs("R9 run after wake-up", 3'd1, 1'b1);
    chk("R9 flag sticky", 32'(proto_err), 32'd1);

    // R1 reset mid-run clears everything at once
    data_in = 24'hFFFFFF;
    rst_n = 1'b0;
    #1;
    check_outputs("R1 mid-run reset", 3'd0, 1'b0);
    chk("R1 mid-run reset err", 32'(proto_err), 32'd0);
    idle_for(2);
    rst_n = 1'b1;
    sck_pulses(LEN_BOOT - 1);
    check_outputs("R2 second boot one short", 3'd0, 1'b0);
    sck_pulses(1);
    check_outputs("R2 second boot done", 3'd1, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule